// File: doc/BRIEF.md
# Bidirectional Common Scan Driver

This block is the digital core of a row (common) driver for a passive matrix LCD. A single line-marker token is loaded at one end of a chain of up to 240 stages. On each falling edge of the line clock the token moves one stage. The chain runs either way, and the two marker pins swap the roles of entry and exit with the direction. Both pins are split into an input, an output value and an output enable, so the pad ring can build the bidirectional pins.

The active chain length can be set to 240, 200 or 160 stages. Unused stages are bypassed, so the far marker pin links to the last active stage. Each stage drives a 2-bit level code that the analog output stage turns into a high, low or middle voltage. The code depends on the stage bit and the frame alternating signal. A display-off input blanks every code at once while the token keeps moving, so the scan position is kept.

Top module: `common_scan_driver`

## Requirements
- R1: While `rst` is high all stages hold 0. Every level code is MID (00), and both marker output values are 0.
- R2: With `shift_left` = 0, on each falling edge of `line_clk` stage 0 loads `marker_a_in` and every other active stage i loads stage i-1. `marker_b_out` shows the last active stage.
- R3: With `shift_left` = 1, on each falling edge the last active stage loads `marker_b_in` and every other active stage i loads stage i+1. `marker_a_out` shows stage 0.
- R4: With `shift_left` = 0, pin A is the input (`marker_a_oe` = 0, `marker_a_out` = 0) and pin B is the output (`marker_b_oe` = 1). With `shift_left` = 1 the roles are swapped.
- R5: `len_mode` sets the active length: 00 gives 240 stages, 01 gives 200, 10 gives 160, and 11 gives 240.
- R6: Stages at index active length and above load 0 on every falling edge, so their codes are MID. A token takes exactly the active length of edges to travel from entry to exit.
- R7: The code of stage i sits at `level_code[2i+1:2i]`. A stage bit of 1 with `m_alt` = 0 gives HIGH (01). A stage bit of 1 with `m_alt` = 1 gives LOW (10). A stage bit of 0 gives MID (00).
- R8: While `disp_off` is 1 every code is MID at once. Shifting goes on unchanged, so the token is where it would have been when `disp_off` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| line_clk | input | 1 | Line shift clock; stages update on its falling edge |
| rst | input | 1 | Asynchronous reset, active high |
| shift_left | input | 1 | Direction: 0 = A to B (stage 0 upward), 1 = B to A |
| len_mode | input | 2 | Active chain length select |
| m_alt | input | 1 | Frame alternating signal |
| disp_off | input | 1 | Display blank, active high |
| marker_a_in | input | 1 | Marker pin A, input value |
| marker_a_out | output | 1 | Marker pin A, output value |
| marker_a_oe | output | 1 | Marker pin A, output enable |
| marker_b_in | input | 1 | Marker pin B, input value |
| marker_b_out | output | 1 | Marker pin B, output value |
| marker_b_oe | output | 1 | Marker pin B, output enable |
| level_code | output | 480 | Per-stage drive-level codes, 2 bits per stage |

## Verification
The scan is tried with single tokens, with tokens two stages apart and with back-to-back tokens, in both directions and in all four length modes. This tells a wrong neighbour tap or a wrong bypass point from a correct shift. Full traversals count the edges from injection to exit, which pins down the length decode for each mode. Toggling `m_alt` and `disp_off` around a moving token separates the HIGH/LOW choice from blanking. It also shows that blanking does not freeze the chain.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    LVL_MID  = 2'b00,
    LVL_HIGH = 2'b01,
    LVL_LOW  = 2'b10
  } level_e;

  // length select decode: 01 and 10 shorten the chain, others give full length
  function automatic int unsigned active_len(input logic [1:0] mode,
                                             input int unsigned full_n,
                                             input int unsigned mid_n,
                                             input int unsigned short_n);
    case (mode)
      2'b01:   return mid_n;
      2'b10:   return short_n;
      default: return full_n;
    endcase
  endfunction

  // drive level from a stage bit, the alternating phase and blanking
  function automatic level_e level_of(input logic stage_bit,
                                      input logic m_phase,
                                      input logic blank);
    if (blank || !stage_bit) return LVL_MID;
    return m_phase ? LVL_LOW : LVL_HIGH;
  endfunction

endpackage

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int unsigned NUM_STAGES = 240,
  parameter int unsigned LEN_W      = $clog2(NUM_STAGES + 1)
) (
  input  logic                  line_clk,
  input  logic                  rst,
  input  logic                  shift_left,
  input  logic [LEN_W-1:0]      act_len,
  input  logic                  head_in,
  input  logic                  tail_in,
  output logic [NUM_STAGES-1:0] stage_q
);

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    localparam logic [LEN_W-1:0] IDX = LEN_W'(i);
    logic in_band;
    logic at_tail;
    logic from_low;
    logic from_high;
    logic nxt;

    assign in_band = IDX < act_len;
    assign at_tail = IDX == (act_len - LEN_W'(1));

    if (i == 0) begin : g_head
      assign from_low = head_in;
    end else begin : g_mid_low
      assign from_low = stage_q[i-1];
    end

    if (i == NUM_STAGES - 1) begin : g_top
      assign from_high = 1'b0;
    end else begin : g_mid_high
      assign from_high = stage_q[i+1];
    end

    always_comb begin
      if (!in_band)        nxt = 1'b0;
      else if (!shift_left) nxt = from_low;
      else if (at_tail)    nxt = tail_in;
      else                 nxt = from_high;
    end

    always_ff @(negedge line_clk or posedge rst) begin
      if (rst) stage_q[i] <= 1'b0;
      else     stage_q[i] <= nxt;
    end
  end

endmodule

// File: rtl/scan_pin_ctrl.sv
module scan_pin_ctrl #(
  parameter int unsigned NUM_STAGES = 240,
  parameter int unsigned LEN_W      = $clog2(NUM_STAGES + 1)
) (
  input  logic                  shift_left,
  input  logic [LEN_W-1:0]      act_len,
  input  logic [NUM_STAGES-1:0] stage_q,
  input  logic                  marker_a_in,
  input  logic                  marker_b_in,
  output logic                  marker_a_out,
  output logic                  marker_a_oe,
  output logic                  marker_b_out,
  output logic                  marker_b_oe,
  output logic                  head_in,
  output logic                  tail_in
);

  localparam int unsigned IDX_W = $clog2(NUM_STAGES);

  logic [IDX_W-1:0] last_idx;
  logic             far_bit;

  assign last_idx = IDX_W'(act_len - LEN_W'(1));
  assign far_bit  = stage_q[last_idx];

  assign marker_a_oe  = shift_left;
  assign marker_b_oe  = !shift_left;
  assign marker_a_out = shift_left ? stage_q[0] : 1'b0;
  assign marker_b_out = shift_left ? 1'b0 : far_bit;

  assign head_in = shift_left ? 1'b0 : marker_a_in;
  assign tail_in = shift_left ? marker_b_in : 1'b0;

endmodule

// File: rtl/scan_level_decode.sv
module scan_level_decode #(
  parameter int unsigned NUM_STAGES = 240
) (
  input  logic [NUM_STAGES-1:0]   stage_q,
  input  logic                    m_alt,
  input  logic                    disp_off,
  output logic [2*NUM_STAGES-1:0] level_code
);
  import scan_pkg::*;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_code
    assign level_code[2*i +: 2] = level_of(stage_q[i], m_alt, disp_off);
  end

endmodule

// File: rtl/common_scan_driver.sv
module common_scan_driver #(
  parameter int unsigned NUM_STAGES   = 240,
  parameter int unsigned MID_STAGES   = 200,
  parameter int unsigned SHORT_STAGES = 160
) (
  input  logic                    line_clk,
  input  logic                    rst,
  input  logic                    shift_left,
  input  logic [1:0]              len_mode,
  input  logic                    m_alt,
  input  logic                    disp_off,
  input  logic                    marker_a_in,
  output logic                    marker_a_out,
  output logic                    marker_a_oe,
  input  logic                    marker_b_in,
  output logic                    marker_b_out,
  output logic                    marker_b_oe,
  output logic [2*NUM_STAGES-1:0] level_code
);
  import scan_pkg::*;

  localparam int unsigned LEN_W = $clog2(NUM_STAGES + 1);

  logic [LEN_W-1:0]      act_len;
  logic [NUM_STAGES-1:0] stage_q;
  logic                  head_in;
  logic                  tail_in;

  assign act_len = LEN_W'(active_len(len_mode, NUM_STAGES, MID_STAGES, SHORT_STAGES));

  scan_pin_ctrl #(.NUM_STAGES(NUM_STAGES), .LEN_W(LEN_W)) u_pins (
    .shift_left  (shift_left),
    .act_len     (act_len),
    .stage_q     (stage_q),
    .marker_a_in (marker_a_in),
    .marker_b_in (marker_b_in),
    .marker_a_out(marker_a_out),
    .marker_a_oe (marker_a_oe),
    .marker_b_out(marker_b_out),
    .marker_b_oe (marker_b_oe),
    .head_in     (head_in),
    .tail_in     (tail_in)
  );

  scan_chain #(.NUM_STAGES(NUM_STAGES), .LEN_W(LEN_W)) u_chain (
    .line_clk  (line_clk),
    .rst       (rst),
    .shift_left(shift_left),
    .act_len   (act_len),
    .head_in   (head_in),
    .tail_in   (tail_in),
    .stage_q   (stage_q)
  );

  scan_level_decode #(.NUM_STAGES(NUM_STAGES)) u_decode (
    .stage_q   (stage_q),
    .m_alt     (m_alt),
    .disp_off  (disp_off),
    .level_code(level_code)
  );

endmodule

// File: rtl/common_scan_driver_chk.sv
module common_scan_driver_chk #(
  parameter int unsigned NUM_STAGES   = 240,
  parameter int unsigned SHORT_STAGES = 160
) (
  input logic                    line_clk,
  input logic                    rst,
  input logic                    shift_left,
  input logic [1:0]              len_mode,
  input logic                    m_alt,
  input logic                    disp_off,
  input logic                    marker_a_in,
  input logic                    marker_b_in,
  input logic                    marker_a_out,
  input logic                    marker_a_oe,
  input logic                    marker_b_out,
  input logic                    marker_b_oe,
  input logic [NUM_STAGES-1:0]   stage_q,
  input logic [2*NUM_STAGES-1:0] level_code
);

  // R2
  fwd_entry_chk: assert property (@(negedge line_clk) disable iff (rst)
    !shift_left |=> stage_q[0] == $past(marker_a_in));

  // R2
  fwd_shift_chk: assert property (@(negedge line_clk) disable iff (rst)
    !shift_left |=> stage_q[1] == $past(stage_q[0]));

  // R3
  bwd_entry_chk: assert property (@(negedge line_clk) disable iff (rst)
    (shift_left && len_mode == 2'b00) |=> stage_q[NUM_STAGES-1] == $past(marker_b_in));

  // R3
  bwd_shift_chk: assert property (@(negedge line_clk) disable iff (rst)
    shift_left |=> stage_q[0] == $past(stage_q[1]));

  // R4
  pin_a_role_chk: assert property (@(negedge line_clk) disable iff (rst)
    marker_a_oe |-> (!marker_b_oe && marker_a_out == stage_q[0]));

  // R4
  pin_b_role_chk: assert property (@(negedge line_clk) disable iff (rst)
    (marker_b_oe && len_mode == 2'b00) |-> (!marker_a_oe && marker_b_out == stage_q[NUM_STAGES-1]));

  // R6
  short_bypass_chk: assert property (@(negedge line_clk) disable iff (rst)
    ($past(len_mode) == 2'b10) |-> stage_q[NUM_STAGES-1:SHORT_STAGES] == '0);

  // R8
  blank_chk: assert property (@(negedge line_clk) disable iff (rst)
    disp_off |-> level_code == '0);

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_code_chk
    // R7
    stage_code_chk: assert property (@(negedge line_clk) disable iff (rst)
      !disp_off |-> level_code[2*i +: 2] ==
        (!stage_q[i] ? 2'b00 : (m_alt ? 2'b10 : 2'b01)));
  end

endmodule

bind common_scan_driver common_scan_driver_chk #(
  .NUM_STAGES  (NUM_STAGES),
  .SHORT_STAGES(SHORT_STAGES)
) u_chk (
  .line_clk    (line_clk),
  .rst         (rst),
  .shift_left  (shift_left),
  .len_mode    (len_mode),
  .m_alt       (m_alt),
  .disp_off    (disp_off),
  .marker_a_in (marker_a_in),
  .marker_b_in (marker_b_in),
  .marker_a_out(marker_a_out),
  .marker_a_oe (marker_a_oe),
  .marker_b_out(marker_b_out),
  .marker_b_oe (marker_b_oe),
  .stage_q     (stage_q),
  .level_code  (level_code)
);

// File: tb/test_common_scan_driver.sv
module test_common_scan_driver;

  localparam int N = 240;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         shift_left = 1'b0;
  logic [1:0]   len_mode = 2'b00;
  logic         m_alt = 1'b0;
  logic         disp_off = 1'b0;
  logic         marker_a_in = 1'b0;
  logic         marker_b_in = 1'b0;
  logic         marker_a_out, marker_a_oe, marker_b_out, marker_b_oe;
  logic [2*N-1:0] level_code;

  common_scan_driver i_common_scan_driver (
    .line_clk    (clk),
    .rst         (rst),
    .shift_left  (shift_left),
    .len_mode    (len_mode),
    .m_alt       (m_alt),
    .disp_off    (disp_off),
    .marker_a_in (marker_a_in),
    .marker_a_out(marker_a_out),
    .marker_a_oe (marker_a_oe),
    .marker_b_in (marker_b_in),
    .marker_b_out(marker_b_out),
    .marker_b_oe (marker_b_oe),
    .level_code  (level_code)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  logic [N-1:0] mdl = '0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected completion before 20000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic int len_for(input logic [1:0] mode);
    if (mode == 2'b10) return 160;
    if (mode == 2'b01) return 200;
    return 240;
  endfunction

  function automatic logic [2*N-1:0] codes_for(input logic [N-1:0] bits,
                                               input logic m, input logic off);
    logic [2*N-1:0] r = '0;
    for (int i = 0; i < N; i++)
      if (bits[i] && !off) r[2*i +: 2] = m ? 2'b10 : 2'b01;
    return r;
  endfunction

  task automatic compare(input string tag);
    logic [2*N-1:0] exp_codes;
    logic [3:0] exp_pins, act_pins;
    int len;
    len = len_for(len_mode);
    exp_codes = codes_for(mdl, m_alt, disp_off);
    if (shift_left) exp_pins = {1'b1, mdl[0], 1'b0, 1'b0};
    else            exp_pins = {1'b0, 1'b0, 1'b1, mdl[len-1]};
    act_pins = {marker_a_oe, marker_a_out, marker_b_oe, marker_b_out};
    checks++;
    if (level_code !== exp_codes) begin
      fails++;
      $display("FAIL %s codes: actual %h expected %h", tag, level_code, exp_codes);
    end
    checks++;
    if (act_pins !== exp_pins) begin
      fails++;
      $display("FAIL %s pins {a_oe,a_out,b_oe,b_out}: actual %b expected %b", tag, act_pins, exp_pins);
    end
  endtask

  // one line clock: drive at the rising edge, shift at the falling edge, compare at next rising edge
  task automatic step(input logic dir, input logic [1:0] mode, input logic m,
                      input logic off, input logic inj, input string tag);
    int len;
    logic [N-1:0] mask;
    shift_left = dir; len_mode = mode; m_alt = m; disp_off = off;
    marker_a_in = dir ? 1'b0 : inj;
    marker_b_in = dir ? inj : 1'b0;
    @(negedge clk);
    len  = len_for(mode);
    mask = (len == N) ? '1 : ((N'(1) << len) - N'(1));
    if (!dir) mdl = ((mdl << 1) | N'(inj)) & mask;
    else      mdl = ((mdl & mask) >> 1) | (N'(inj) << (len - 1));
    @(posedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    @(posedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    mdl = '0;
    compare(tag);
    checks++;
    if (marker_a_out !== 1'b0 || marker_b_out !== 1'b0) begin
      fails++;
      $display("FAIL %s marker outputs: actual %b%b expected 00", tag, marker_a_out, marker_b_out);
    end
    rst = 1'b0;
  endtask

  task automatic traverse(input logic dir, input logic [1:0] mode, input int exp_n, input string tag);
    int n;
    step(dir, mode, 1'b0, 1'b0, 1'b1, tag);
    n = 1;
    while (!(dir ? marker_a_out : marker_b_out) && n < 300) begin
      step(dir, mode, n[0], 1'b0, 1'b0, tag);
      n++;
    end
    checks++;
    if (n != exp_n) begin
      fails++;
      $display("FAIL %s traversal edges: actual %0d expected %0d", tag, n, exp_n);
    end
  endtask

  // entry bits: [5] dir, [4:3] len_mode, [2] m_alt, [1] disp_off, [0] inject
  localparam int NV = 18;
  localparam logic [5:0] VEC [NV] = '{
    6'b0_00_0_0_1, 6'b0_00_0_0_0, 6'b0_00_1_0_1, 6'b0_00_1_0_1,
    6'b0_00_0_1_0, 6'b0_00_1_0_0, 6'b0_01_0_0_1, 6'b0_10_1_0_0,
    6'b1_00_0_0_1, 6'b1_00_1_0_0, 6'b1_00_0_0_1, 6'b1_01_0_0_1,
    6'b1_01_1_1_0, 6'b1_10_0_0_1, 6'b1_11_1_0_0, 6'b0_11_0_0_1,
    6'b0_11_1_0_1, 6'b1_00_0_0_0
  };

  initial begin
    // R1 reset state
    do_reset("R1 reset");

    // R2 R3 R4 R5 R7 R8 table walk
    for (int k = 0; k < NV; k++)
      step(VEC[k][5], VEC[k][4:3], VEC[k][2], VEC[k][1], VEC[k][0], "R2 R3 R4 R7 table");

    // R1 reset mid-run clears tokens
    do_reset("R1 mid-run");

    // R5 R6 short chain forward: 160 edges to exit at pin B
    traverse(1'b0, 2'b10, 160, "R6 short fwd");
    do_reset("R1 before mid");
    // R5 R3 mid chain backward: 200 edges to exit at pin A
    traverse(1'b1, 2'b01, 200, "R5 mid bwd");
    do_reset("R1 before alt");
    // R5 mode 11 acts as full length
    traverse(1'b0, 2'b11, 240, "R5 alt full");

    // R8 blanking while the token keeps moving
    do_reset("R1 before blank");
    step(1'b0, 2'b00, 1'b0, 1'b0, 1'b1, "R7 inject");
    for (int k = 0; k < 5; k++) step(1'b0, 2'b00, 1'b1, 1'b1, 1'b0, "R8 blank");
    step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0, "R8 release");
    checks++;
    if (level_code[2*6 +: 2] !== 2'b10) begin
      fails++;
      $display("FAIL R8 token after blank: actual %b expected 10", level_code[2*6 +: 2]);
    end

    // R6 bypassed stages cleared when switching from full to short length
    do_reset("R1 before bypass");
    for (int k = 0; k < 170; k++) step(1'b0, 2'b00, 1'b0, 1'b0, (k == 0), "R2 fill");
    step(1'b0, 2'b10, 1'b0, 1'b0, 1'b0, "R6 switch short");
    checks++;
    if (level_code[2*N-1:2*160] !== '0) begin
      fails++;
      $display("FAIL R6 bypassed codes: actual %h expected 0", level_code[2*N-1:2*160]);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule